// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped cache that the fetch stage consults to learn the next PC before the fetched instruction has been decoded. Each cycle the fetch unit presents its current PC. Within the same cycle the block returns a hit flag, the stored target and the resulting next PC. On a hit the next PC is the stored target. On a miss fetch continues with the sequential address, PC + 4. Only branches that were taken have entries. Each entry holds a valid bit, a tag taken from the PC bits above the index, and the full target address.

When a branch resolves later in the pipeline, the resolve port receives the branch PC, its outcome and its actual target. The block looks the branch PC up again to classify the outcome, and then does one of the following:

- inserts an entry for a taken branch that missed;
- removes an entry whose branch fell through;
- rewrites an entry whose taken target changed.

In the last three cases it raises a redirect toward the correct path, reports the penalty in cycles, and holds fetch for that many cycles. Correct predictions, and misses on instructions that are not taken branches, cost nothing.

Top module: `branch_target_buffer`

## Requirements
- R1: A lookup hits when the indexed entry is valid and its tag equals the fetch PC tag. On a hit, `pred_hit` is 1 and `pred_next_pc` equals `pred_target`, in the same cycle as `fetch_pc`.
- R2: On a lookup miss, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`.
- R3: A resolved branch that hits and is taken to the stored target raises no redirect, reports a penalty of 0 and leaves the entry unchanged.
- R4: A resolved branch that misses and is not taken raises no redirect, reports a penalty of 0 and writes nothing, so a later lookup of that PC still misses.
- R5: A resolved branch that hits but is not taken raises `redirect_valid`, with `redirect_pc` equal to `res_pc + 4` and a penalty of PENALTY (2). From the next cycle on, that entry no longer hits.
- R6: A resolved branch that misses but is taken raises `redirect_valid`, with `redirect_pc` equal to `res_target` and a penalty of PENALTY. From the next cycle on, that PC hits with `res_target`.
- R7: A resolved branch that hits and is taken to a target different from the stored one raises `redirect_valid` toward `res_target` with a penalty of PENALTY. From the next cycle on, the entry returns the new target.
- R8: After the clock edge that accepts a redirect, `fetch_hold` is 1 for exactly PENALTY cycles and then returns to 0. A correct prediction never raises it.
- R9: Reset (synchronous, active high) clears every valid bit, so every lookup after reset misses.
- R10: The index is PC bits [IDX_W+1:2] and the tag is the TAG_W bits above the index. A PC with the same index but a different tag replaces the existing entry. PCs that differ only above the tag bits alias to the same entry and hit.
- R11: A lookup in the same cycle as a resolve write sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC being fetched |
| pred_hit | output | 1 | Lookup hit |
| pred_target | output | PC_W | Stored target of the indexed entry |
| pred_next_pc | output | PC_W | Predicted next fetch PC |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Resolved direction, 1 = taken |
| res_target | input | PC_W | Actual taken target |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Correct-path PC |
| penalty_cycles | output | CNT_W | Penalty charged for this resolve |
| fetch_hold | output | 1 | Fetch stalled while the penalty elapses |

## Verification
The bench builds the block with 8 entries, a 6-bit tag, 32-bit PCs and a penalty of 2. With these values the index sits in PC bits [4:2] and the tag in bits [10:5], so the addresses 0x100 and 0x120 collide on index 0 with different tags. The address 0x900 differs from 0x100 only above the tag and therefore aliases onto it. These widths make replacement, false aliasing and all five resolve outcomes reachable with a handful of hand-picked addresses. The hold window is short enough to check cycle by cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int INSTR_BYTES = 4;
    localparam int OFFSET_BITS = 2;

    typedef enum logic [2:0] {
        RES_NONE,
        RES_CORRECT,
        RES_QUIET_MISS,
        RES_FALSE_HIT,
        RES_WRONG_TGT,
        RES_NEW_TAKEN
    } res_kind_e;

    typedef struct packed {
        logic      wr;
        logic      wr_valid;
        logic      redirect;
        res_kind_e kind;
    } res_ctl_t;

    function automatic logic needs_write(res_kind_e k);
        return (k == RES_FALSE_HIT) || (k == RES_WRONG_TGT) || (k == RES_NEW_TAKEN);
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] rd_pc     [2],
    output logic            rd_hit    [2],
    output logic [PC_W-1:0] rd_target [2],
    input  logic            wr_en,
    input  logic            wr_valid,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target
);
    import btb_pkg::*;

    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TAG_LO = OFFSET_BITS + IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];

    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    assign wr_idx = wr_pc[OFFSET_BITS +: IDX_W];
    assign wr_tag = wr_pc[TAG_LO +: TAG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en && wr_valid) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        assign idx          = rd_pc[p][OFFSET_BITS +: IDX_W];
        assign tag          = rd_pc[p][TAG_LO +: TAG_W];
        assign rd_hit[p]    = valid_q[idx] && (tag_q[idx] == tag);
        assign rd_target[p] = tgt_q[idx];
    end

    // R9: the first cycle after reset sees no valid entry
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0));

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
    parameter int PC_W    = 32,
    parameter int PENALTY = 2,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  res_target,
    input  logic             hit,
    input  logic [PC_W-1:0]  stored_target,
    output btb_pkg::res_ctl_t ctl,
    output logic [PC_W-1:0]  redirect_pc,
    output logic [CNT_W-1:0] penalty
);
    import btb_pkg::*;

    res_kind_e kind;

    always_comb begin
        if (!res_valid)
            kind = RES_NONE;
        else if (hit && !res_taken)
            kind = RES_FALSE_HIT;
        else if (hit)
            kind = (stored_target == res_target) ? RES_CORRECT : RES_WRONG_TGT;
        else if (res_taken)
            kind = RES_NEW_TAKEN;
        else
            kind = RES_QUIET_MISS;
    end

    always_comb begin
        ctl.kind     = kind;
        ctl.wr       = needs_write(kind);
        ctl.wr_valid = (kind != RES_FALSE_HIT);
        ctl.redirect = needs_write(kind);
    end

    assign redirect_pc = res_taken ? res_target : res_pc + PC_W'(INSTR_BYTES);
    assign penalty     = ctl.redirect ? CNT_W'(PENALTY) : '0;

    // R5: a hit that falls through must redirect to the sequential path
    a_r5_false_hit_redirects: assert property (@(posedge clk) disable iff (rst)
        (res_valid && hit && !res_taken) |-> (ctl.redirect && redirect_pc == res_pc + PC_W'(INSTR_BYTES)));

    // R3: a correct taken hit is silent
    a_r3_correct_silent: assert property (@(posedge clk) disable iff (rst)
        (res_valid && hit && res_taken && stored_target == res_target) |-> (!ctl.redirect && penalty == '0));

    // R4: a not-taken miss never writes
    a_r4_quiet_no_write: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !hit && !res_taken) |-> !ctl.wr);

endmodule

// File: rtl/btb_hold_timer.sv
module btb_hold_timer #(
    parameter int PENALTY = 2,
    parameter int CNT_W   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic hold
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(PENALTY);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign hold = (cnt_q != '0);

    // R8: a redirect opens the hold window on the next cycle
    a_r8_hold_opens: assert property (@(posedge clk) disable iff (rst)
        start |=> hold);

    // R8: the window never exceeds the penalty
    a_r8_hold_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(PENALTY));

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 8,
    parameter int PENALTY = 2,
    localparam int CNT_W  = $clog2(PENALTY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_hit,
    output logic [PC_W-1:0]  pred_target,
    output logic [PC_W-1:0]  pred_next_pc,
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  res_target,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic [CNT_W-1:0] penalty_cycles,
    output logic             fetch_hold
);
    import btb_pkg::*;

    logic [PC_W-1:0] rd_pc     [2];
    logic            rd_hit    [2];
    logic [PC_W-1:0] rd_target [2];
    res_ctl_t        ctl;

    assign rd_pc[0] = fetch_pc;
    assign rd_pc[1] = res_pc;

    btb_store #(.PC_W(PC_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_pc     (rd_pc),
        .rd_hit    (rd_hit),
        .rd_target (rd_target),
        .wr_en     (ctl.wr),
        .wr_valid  (ctl.wr_valid),
        .wr_pc     (res_pc),
        .wr_target (res_target)
    );

    btb_resolve #(.PC_W(PC_W), .PENALTY(PENALTY), .CNT_W(CNT_W)) u_resolve (
        .clk           (clk),
        .rst           (rst),
        .res_valid     (res_valid),
        .res_pc        (res_pc),
        .res_taken     (res_taken),
        .res_target    (res_target),
        .hit           (rd_hit[1]),
        .stored_target (rd_target[1]),
        .ctl           (ctl),
        .redirect_pc   (redirect_pc),
        .penalty       (penalty_cycles)
    );

    btb_hold_timer #(.PENALTY(PENALTY), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (ctl.redirect),
        .hold  (fetch_hold)
    );

    assign pred_hit       = rd_hit[0];
    assign pred_target    = rd_target[0];
    assign pred_next_pc   = rd_hit[0] ? rd_target[0] : fetch_pc + PC_W'(INSTR_BYTES);
    assign redirect_valid = ctl.redirect;

    // R2: a miss continues sequentially
    a_r2_miss_sequential: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (pred_next_pc == fetch_pc + PC_W'(INSTR_BYTES)));

    // R6: a taken write is visible to the following lookup of the same PC
    a_r6_insert_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(redirect_valid && res_taken && !rst) && fetch_pc == $past(res_pc))
            |-> (pred_hit && pred_target == $past(res_target)));

    // R5: a removed entry misses on the following lookup of the same PC
    a_r5_removed_misses: assert property (@(posedge clk) disable iff (rst)
        ($past(redirect_valid && !res_taken && !rst) && fetch_pc == $past(res_pc)) |-> !pred_hit);

endmodule

// File: tb/branch_target_buffer_tb.sv
module branch_target_buffer_tb;

    localparam int PC_W    = 32;
    localparam int ENTRIES = 8;
    localparam int TAG_W   = 6;
    localparam int PENALTY = 2;
    localparam int CNT_W   = $clog2(PENALTY + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic [PC_W-1:0]  fetch_pc;
    logic             pred_hit;
    logic [PC_W-1:0]  pred_target;
    logic [PC_W-1:0]  pred_next_pc;
    logic             res_valid;
    logic [PC_W-1:0]  res_pc;
    logic             res_taken;
    logic [PC_W-1:0]  res_target;
    logic             redirect_valid;
    logic [PC_W-1:0]  redirect_pc;
    logic [CNT_W-1:0] penalty_cycles;
    logic             fetch_hold;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    branch_target_buffer #(.PC_W(PC_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W), .PENALTY(PENALTY)) u_dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
        .pred_target(pred_target), .pred_next_pc(pred_next_pc), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .penalty_cycles(penalty_cycles), .fetch_hold(fetch_hold)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic lookup(input string req, input logic [31:0] pc, input logic hit, input logic [31:0] nxt);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        chk({req, " hit"}, 64'(pred_hit), 64'(hit));
        chk({req, " next pc"}, 64'(pred_next_pc), 64'(nxt));
    endtask

    task automatic resolve(input string req, input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                           input logic redir, input logic [31:0] rpc);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
        #1;
        chk({req, " redirect"}, 64'(redirect_valid), 64'(redir));
        if (redir) chk({req, " redirect pc"}, 64'(redirect_pc), 64'(rpc));
        chk({req, " penalty"}, 64'(penalty_cycles), redir ? 64'(PENALTY) : 64'd0);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; res_valid = 1'b0; res_pc = '0; res_taken = 1'b0; res_target = '0; fetch_pc = 32'h100;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 reset hold", 64'(fetch_hold), 64'd0);
        chk("R9 reset redirect", 64'(redirect_valid), 64'd0);
        lookup("R9/R2 after reset", 32'h100, 1'b0, 32'h104);
    endtask

    task automatic t_quiet_miss;
        resolve("R4 quiet miss", 32'h100, 1'b0, 32'h0, 1'b0, 32'h0);
        lookup("R4 nothing written", 32'h100, 1'b0, 32'h104);
    endtask

    task automatic t_insert;
        @(negedge clk);
        fetch_pc = 32'h100;
        res_valid = 1'b1; res_pc = 32'h100; res_taken = 1'b1; res_target = 32'h2000;
        #1;
        chk("R11 lookup sees old contents", 64'(pred_hit), 64'd0);
        chk("R6 redirect", 64'(redirect_valid), 64'd1);
        chk("R6 redirect pc", 64'(redirect_pc), 64'h2000);
        chk("R6 penalty", 64'(penalty_cycles), 64'(PENALTY));
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        chk("R8 hold cycle 1", 64'(fetch_hold), 64'd1);
        chk("R6/R1 inserted hit", 64'(pred_hit), 64'd1);
        chk("R1 next pc = target", 64'(pred_next_pc), 64'h2000);
        @(negedge clk); #1;
        chk("R8 hold cycle 2", 64'(fetch_hold), 64'd1);
        @(negedge clk); #1;
        chk("R8 hold released", 64'(fetch_hold), 64'd0);
    endtask

    task automatic t_correct;
        resolve("R3 correct hit", 32'h100, 1'b1, 32'h2000, 1'b0, 32'h0);
        #1;
        chk("R8 no hold on correct", 64'(fetch_hold), 64'd0);
        lookup("R3 entry unchanged", 32'h100, 1'b1, 32'h2000);
    endtask

    task automatic t_wrong_target;
        resolve("R7 wrong target", 32'h100, 1'b1, 32'h3000, 1'b1, 32'h3000);
        lookup("R7 target rewritten", 32'h100, 1'b1, 32'h3000);
    endtask

    task automatic t_alias;
        lookup("R10 upper bits alias", 32'h900, 1'b1, 32'h3000);
        resolve("R10 conflict insert", 32'h120, 1'b1, 32'h4000, 1'b1, 32'h4000);
        lookup("R10 old tag evicted", 32'h100, 1'b0, 32'h104);
        lookup("R10 new tag hits", 32'h120, 1'b1, 32'h4000);
    endtask

    task automatic t_false_hit;
        resolve("R5 hit not taken", 32'h120, 1'b0, 32'h0, 1'b1, 32'h124);
        lookup("R5 entry removed", 32'h120, 1'b0, 32'h124);
    endtask

    task automatic t_reset_clears;
        resolve("R6 insert idx1", 32'h104, 1'b1, 32'h5000, 1'b1, 32'h5000);
        lookup("R1 idx1 hit", 32'h104, 1'b1, 32'h5000);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lookup("R9 reset clears entry", 32'h104, 1'b0, 32'h108);
    endtask

    initial begin
        t_reset();
        t_quiet_miss();
        t_insert();
        t_correct();
        t_wrong_target();
        t_alias();
        t_false_hit();
        t_reset_clears();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule